// File: doc/BRIEF.md
# Two-Line Interrupt Router

The block gathers interrupt requests from a set of external pins and from on-chip peripherals. Each request becomes a pending bit. Each pending bit can be gated by its own enable and steered to one of two processor lines: a fast line (FIQ) or a normal line (IRQ). The block does not rank requests. Software reads a status word to find which source is active and applies its own ordering.

Each external pin passes through a two-flop synchronizer. The lowest-numbered pins also pass through a digital noise filter. That filter passes a new level only after the level has held for a parameterised number of consecutive samples, including the current one. Each external pin is then detected by its level, by a rising edge or by a falling edge. Edge-detected pins hold a pending bit until software writes a one to that bit. Level-detected pins and internal requests show their live state. Both processor lines are registered.

A small register port gives access to the block. Writes are single-cycle strobes. Reads are combinational from the address.

Top module: `irqRouter`

## Requirements
- R1: After reset, all enables read 0, all routes read 0 (IRQ), all detection modes read 00 (level), the raw status reads 0 with inputs idle, and both fiq and irq are low.
- R2: A source whose enable bit is 0 never drives fiq or irq, whatever its request or route.
- R3: fiq is high one cycle after any source is pending, enabled and has route bit 1. irq behaves the same way for route bit 0. Each line is the OR over the sources routed to it.
- R4: Internal requests are active-high levels. Raw status bit NUM_EXT+j follows intReq[j] live, and a clear write has no effect on it.
- R5: An external pin in level mode (mode 00 or 11) shows its synchronized, filtered level at its raw status bit. Writing 1 to that bit has no effect.
- R6: In rising mode (mode 01), a low-to-high change of the conditioned pin sets a sticky pending bit. The bit stays set after the pin returns low, until a write of 1 to that bit at address 0.
- R7: In falling mode (mode 10), a high-to-low change of the conditioned pin sets the sticky pending bit. Switching a pin that is already high into falling mode does not set the bit.
- R8: External pins 0 to NUM_FILT-1 reject any pulse shorter than FILT_LEN samples and accept a pulse of FILT_LEN samples.
- R9: External pins at index NUM_FILT and above use only the synchronizer, so a one-cycle pulse is captured in edge mode.
- R10: Address 1 reads raw status AND enable.
- R11: Register map:
  - Address 0: raw status (read) and write-1-to-clear.
  - Address 2: enable.
  - Address 3: route (1 = FIQ).
  - Address 4: detection mode, with pin i at bits [2i+1:2i].
  - Source k sits at bit k. External pins come first, then internal requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| extIn | input | NUM_EXT | Asynchronous external request pins |
| intReq | input | NUM_INT | Internal active-high request levels |
| wrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Read data for regAddr |
| fiq | output | 1 | Fast interrupt line |
| irq | output | 1 | Normal interrupt line |

## Verification
The bench builds the block with three external pins, two of them filtered, and five internal requests. This gives eight sources in total. With eight sources, a sweep can cover every source against every enable, route and request value. It checks both lines and both status views each time. The small filter window and the mix of filtered and unfiltered pins let the bench try pulses just below and at the acceptance length, and single-cycle pulses on the unfiltered pin, in each detection mode.

// File: rtl/irqPkg.sv
package irqPkg;
  typedef enum logic [1:0] {
    MODE_LEVEL  = 2'b00,
    MODE_RISE   = 2'b01,
    MODE_FALL   = 2'b10,
    MODE_LEVEL2 = 2'b11
  } detMode_e;

  typedef struct packed {
    logic clrPend;
    logic wrEnable;
    logic wrRoute;
    logic wrMode;
  } regStrobe_t;

  localparam logic [2:0] ADDR_RAW    = 3'd0;
  localparam logic [2:0] ADDR_MASKED = 3'd1;
  localparam logic [2:0] ADDR_ENABLE = 3'd2;
  localparam logic [2:0] ADDR_ROUTE  = 3'd3;
  localparam logic [2:0] ADDR_MODE   = 3'd4;
endpackage

// File: rtl/irqFilter.sv
module irqFilter #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [FILT_LEN-2:0] hist;
  logic [FILT_LEN-1:0] window;

  assign window = {hist, din};

  always_ff @(posedge clk) begin
    if (rst) begin
      hist <= '0;
      dout <= 1'b0;
    end else begin
      hist <= {hist[FILT_LEN-3:0], din};
      if (&window)       dout <= 1'b1;
      else if (~|window) dout <= 1'b0;
    end
  end
endmodule

// File: rtl/irqCtrl.sv
module irqCtrl
  import irqPkg::*;
(
  input  logic       wrEn,
  input  logic [2:0] regAddr,
  output regStrobe_t strobe
);
  always_comb begin
    strobe          = '0;
    strobe.clrPend  = wrEn && (regAddr == ADDR_RAW);
    strobe.wrEnable = wrEn && (regAddr == ADDR_ENABLE);
    strobe.wrRoute  = wrEn && (regAddr == ADDR_ROUTE);
    strobe.wrMode   = wrEn && (regAddr == ADDR_MODE);
  end
endmodule

// File: rtl/irqDatapath.sv
module irqDatapath
  import irqPkg::*;
#(
  parameter int NUM_EXT  = 3,
  parameter int NUM_INT  = 23,
  parameter int NUM_FILT = 2,
  parameter int FILT_LEN = 4,
  parameter int DATA_W   = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NUM_EXT-1:0]           extIn,
  input  logic [NUM_INT-1:0]           intReq,
  input  regStrobe_t                   strobe,
  input  logic [DATA_W-1:0]            wrData,
  input  logic [2:0]                   regAddr,
  output logic [DATA_W-1:0]            rdData,
  output logic [NUM_EXT+NUM_INT-1:0]   pending,
  output logic [NUM_EXT+NUM_INT-1:0]   enable,
  output logic [NUM_EXT+NUM_INT-1:0]   route,
  output logic [2*NUM_EXT-1:0]         modeBits,
  output logic                         fiq,
  output logic                         irq
);
  localparam int NUM_SRC = NUM_EXT + NUM_INT;

  logic [NUM_EXT-1:0] sync1, sync2, cond, prevCond, pendEdge, isEdge, hit;
  logic [NUM_SRC-1:0] masked;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= extIn;
      sync2 <= sync1;
    end
  end

  for (genvar i = 0; i < NUM_EXT; i++) begin : g_ext
    if (i < NUM_FILT) begin : g_filt
      irqFilter #(.FILT_LEN(FILT_LEN)) u_filt (
        .clk(clk), .rst(rst), .din(sync2[i]), .dout(cond[i])
      );
    end else begin : g_raw
      assign cond[i] = sync2[i];
    end

    detMode_e modeI;
    assign modeI     = detMode_e'(modeBits[2*i +: 2]);
    assign isEdge[i] = (modeI == MODE_RISE) || (modeI == MODE_FALL);
    assign hit[i]    = (modeI == MODE_RISE) ? (cond[i] & ~prevCond[i]) :
                       (modeI == MODE_FALL) ? (~cond[i] & prevCond[i]) : 1'b0;

    always_ff @(posedge clk) begin
      if (rst) begin
        pendEdge[i] <= 1'b0;
      end else if (isEdge[i]) begin
        pendEdge[i] <= (pendEdge[i] & ~(strobe.clrPend & wrData[i])) | hit[i];
      end else begin
        pendEdge[i] <= 1'b0;
      end
    end

    assign pending[i] = isEdge[i] ? pendEdge[i] : cond[i];
  end

  assign pending[NUM_SRC-1:NUM_EXT] = intReq;

  always_ff @(posedge clk) begin
    if (rst) begin
      prevCond <= '0;
      enable   <= '0;
      route    <= '0;
      modeBits <= '0;
      fiq      <= 1'b0;
      irq      <= 1'b0;
    end else begin
      prevCond <= cond;
      if (strobe.wrEnable) enable   <= wrData[NUM_SRC-1:0];
      if (strobe.wrRoute)  route    <= wrData[NUM_SRC-1:0];
      if (strobe.wrMode)   modeBits <= wrData[2*NUM_EXT-1:0];
      fiq <= |(masked & route);
      irq <= |(masked & ~route);
    end
  end

  assign masked = pending & enable;

  always_comb begin
    rdData = '0;
    case (regAddr)
      ADDR_RAW:    rdData[NUM_SRC-1:0]   = pending;
      ADDR_MASKED: rdData[NUM_SRC-1:0]   = masked;
      ADDR_ENABLE: rdData[NUM_SRC-1:0]   = enable;
      ADDR_ROUTE:  rdData[NUM_SRC-1:0]   = route;
      ADDR_MODE:   rdData[2*NUM_EXT-1:0] = modeBits;
      default:     rdData = '0;
    endcase
  end
endmodule

// File: rtl/irqRouter.sv
module irqRouter
  import irqPkg::*;
#(
  parameter int NUM_EXT  = 3,
  parameter int NUM_INT  = 23,
  parameter int NUM_FILT = 2,
  parameter int FILT_LEN = 4,
  parameter int DATA_W   = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_EXT-1:0] extIn,
  input  logic [NUM_INT-1:0] intReq,
  input  logic               wrEn,
  input  logic [2:0]         regAddr,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  output logic               fiq,
  output logic               irq
);
  localparam int NUM_SRC = NUM_EXT + NUM_INT;

  regStrobe_t          strobe;
  logic [NUM_SRC-1:0]  pending, enable, route;
  logic [2*NUM_EXT-1:0] modeBits;

  irqCtrl u_ctrl (.wrEn(wrEn), .regAddr(regAddr), .strobe(strobe));

  irqDatapath #(
    .NUM_EXT(NUM_EXT), .NUM_INT(NUM_INT), .NUM_FILT(NUM_FILT),
    .FILT_LEN(FILT_LEN), .DATA_W(DATA_W)
  ) u_dp (
    .clk(clk), .rst(rst), .extIn(extIn), .intReq(intReq), .strobe(strobe),
    .wrData(wrData), .regAddr(regAddr), .rdData(rdData), .pending(pending),
    .enable(enable), .route(route), .modeBits(modeBits), .fiq(fiq), .irq(irq)
  );
endmodule

// File: rtl/irqRouterChk.sv
module irqRouterChk #(
  parameter int NUM_EXT = 3,
  parameter int NUM_SRC = 26,
  parameter int DATA_W  = 32
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 fiq,
  input logic                 irq,
  input logic [NUM_SRC-1:0]   pending,
  input logic [NUM_SRC-1:0]   enable,
  input logic [NUM_SRC-1:0]   route,
  input logic [2*NUM_EXT-1:0] modeBits,
  input logic                 wrEn,
  input logic [2:0]           regAddr,
  input logic [DATA_W-1:0]    wrData
);
  // R2: with every enable clear, neither line rises on the next cycle
  p_disabled_silent_r2: assert property (@(posedge clk) disable iff (rst)
    (enable == '0) |=> (!fiq && !irq));

  // R3: fiq only follows a pending, enabled, FIQ-routed source
  p_fiq_source_r3: assert property (@(posedge clk) disable iff (rst)
    fiq |-> $past(|(pending & enable & route)));

  // R3: irq only follows a pending, enabled, IRQ-routed source
  p_irq_source_r3: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(|(pending & enable & ~route)));

  for (genvar i = 0; i < NUM_EXT; i++) begin : g_sticky
    // R6: an edge-mode pending bit holds unless cleared or the mode is rewritten
    p_sticky_hold_r6: assert property (@(posedge clk) disable iff (rst)
      (pending[i] && (^modeBits[2*i +: 2]) && !wrEn) |=> pending[i]);
  end
endmodule

bind irqRouter irqRouterChk #(
  .NUM_EXT(NUM_EXT), .NUM_SRC(NUM_EXT + NUM_INT), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst(rst), .fiq(fiq), .irq(irq), .pending(pending),
  .enable(enable), .route(route), .modeBits(modeBits), .wrEn(wrEn),
  .regAddr(regAddr), .wrData(wrData)
);

// File: tb/tb_irqRouter.sv
module tb_irqRouter;
  localparam int NUM_EXT = 3;
  localparam int NUM_INT = 5;
  localparam int NUM_FILT = 2;
  localparam int FILT_LEN = 4;
  localparam int DATA_W = 32;
  localparam int NUM_SRC = NUM_EXT + NUM_INT;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NUM_EXT-1:0] extIn = '0;
  logic [NUM_INT-1:0] intReq = '0;
  logic wrEn = 1'b0;
  logic [2:0] regAddr = '0;
  logic [DATA_W-1:0] wrData = '0;
  logic [DATA_W-1:0] rdData;
  logic fiq, irq;

  int nChecks = 0;
  int nFails = 0;

  always #2.5 clk = ~clk;

  irqRouter #(.NUM_EXT(NUM_EXT), .NUM_INT(NUM_INT), .NUM_FILT(NUM_FILT),
              .FILT_LEN(FILT_LEN), .DATA_W(DATA_W)) dut (
    .clk(clk), .rst(rst), .extIn(extIn), .intReq(intReq), .wrEn(wrEn),
    .regAddr(regAddr), .wrData(wrData), .rdData(rdData), .fiq(fiq), .irq(irq)
  );

  task automatic chk(input string tag, input logic [DATA_W-1:0] act,
                     input logic [DATA_W-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    wrEn = 1'b1; regAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [DATA_W-1:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = rdData;
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int idx, input int len);
    @(negedge clk);
    extIn[idx] = 1'b1;
    repeat (len) @(negedge clk);
    extIn[idx] = 1'b0;
    waitCyc(12);
  endtask

  initial begin
    #400000;
    nChecks++; nFails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    logic [DATA_W-1:0] v;
    waitCyc(3);
    @(negedge clk) rst = 1'b0;
    // R1 reset state
    rd(3'd2, v); chk("R1 enable", v, '0);
    rd(3'd3, v); chk("R1 route", v, '0);
    rd(3'd4, v); chk("R1 mode", v, '0);
    rd(3'd0, v); chk("R1 raw", v, '0);
    chk("R1 fiq", {31'b0, fiq}, '0);
    chk("R1 irq", {31'b0, irq}, '0);

    // Sweep every source against enable, route and request (R2 R3 R4 R5 R10)
    for (int s = 0; s < NUM_SRC; s++) begin
      for (int combo = 0; combo < 8; combo++) begin
        logic en, rt, rq;
        en = combo[0]; rt = combo[1]; rq = combo[2];
        wr(3'd2, DATA_W'(en) << s);
        wr(3'd3, DATA_W'(rt) << s);
        @(negedge clk);
        if (s < NUM_EXT) extIn[s] = rq; else intReq[s-NUM_EXT] = rq;
        waitCyc(10);
        rd(3'd0, v); chk(s < NUM_EXT ? "R5 raw level" : "R4 raw live", v, DATA_W'(rq) << s);
        rd(3'd1, v); chk("R10 masked", v, DATA_W'(rq & en) << s);
        chk(en ? "R3 fiq" : "R2 fiq", {31'b0, fiq}, {31'b0, rq & en & rt});
        chk(en ? "R3 irq" : "R2 irq", {31'b0, irq}, {31'b0, rq & en & ~rt});
        if (rq) begin
          wr(3'd0, DATA_W'(1) << s);
          rd(3'd0, v); chk(s < NUM_EXT ? "R5 clear ignored" : "R4 clear ignored", v, DATA_W'(1) << s);
        end
        @(negedge clk);
        extIn = '0; intReq = '0;
        waitCyc(10);
      end
    end

    // R3: OR of two FIQ sources, one removed
    wr(3'd2, 32'h18); wr(3'd3, 32'h18);
    @(negedge clk) intReq = 5'b00011;
    waitCyc(3);
    chk("R3 fiq or", {31'b0, fiq}, 32'd1);
    @(negedge clk) intReq = 5'b00010;
    waitCyc(3);
    chk("R3 fiq or one left", {31'b0, fiq}, 32'd1);
    chk("R3 irq quiet", {31'b0, irq}, 32'd0);
    @(negedge clk) intReq = '0;
    waitCyc(3);

    // R6: rising, sticky, write-1-to-clear
    wr(3'd4, 32'h01);
    rd(3'd4, v); chk("R11 mode readback", v, 32'h01);
    wr(3'd2, 32'h01); wr(3'd3, 32'h01);
    pulse(0, 6);
    rd(3'd0, v); chk("R6 sticky", v, 32'h01);
    chk("R6 fiq", {31'b0, fiq}, 32'd1);
    wr(3'd0, 32'h01);
    waitCyc(2);
    rd(3'd0, v); chk("R6 cleared", v, 32'h00);
    chk("R6 fiq low", {31'b0, fiq}, 32'd0);

    // R8: filtered pins reject short pulses
    pulse(0, FILT_LEN - 1);
    rd(3'd0, v); chk("R8 pin0 short", v, 32'h00);
    pulse(0, FILT_LEN);
    rd(3'd0, v); chk("R8 pin0 accept", v, 32'h01);
    wr(3'd0, 32'h01);
    wr(3'd4, 32'h04);
    pulse(1, FILT_LEN - 1);
    rd(3'd0, v); chk("R8 pin1 short", v, 32'h00);
    pulse(1, FILT_LEN);
    rd(3'd0, v); chk("R8 pin1 accept", v, 32'h02);
    wr(3'd0, 32'h02);

    // R9: unfiltered pin takes a one-cycle pulse
    wr(3'd4, 32'h10);
    pulse(2, 1);
    rd(3'd0, v); chk("R9 pin2 short", v, 32'h04);
    wr(3'd0, 32'h04);
    rd(3'd0, v); chk("R6 pin2 cleared", v, 32'h00);

    // R7: falling mode
    wr(3'd4, 32'h00);
    @(negedge clk) extIn[2] = 1'b1;
    waitCyc(6);
    wr(3'd4, 32'h20);
    waitCyc(3);
    rd(3'd0, v); chk("R7 no set on entry", v, 32'h00);
    @(negedge clk) extIn[2] = 1'b0;
    waitCyc(6);
    rd(3'd0, v); chk("R7 falling set", v, 32'h04);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule